// File: doc/BRIEF.md
# FIFO DMA Burst Master Sequencer

This block is the bus-master side of a FIFO DMA path. Software-side logic hands it a start byte address, a byte count and a direction. The block then moves that many bytes between system memory and an internal FIFO. It wins the bus with a request/grant pair, issues an address phase, and runs data phases until one of three things happens: the job ends, the FIFO reaches its watermark, or the grant is withdrawn. If work remains, it asks for the bus again later and resumes at the next word address. Every transfer in one bus ownership goes the same way and covers ascending, contiguous word addresses.

Reads fill the FIFO from memory. They stop once the FIFO level would reach the high watermark, and they always enable all four byte lanes. Writes drain the FIFO into memory. They stop once the level would fall to the low watermark. Each write phase enables only the lanes that lie inside the buffer, so an unaligned start or end gives a partial first or last phase. Each direction has its own burst-enable bit. With the bit clear, every transfer is one address phase followed by a single data phase. Read data on the bus is captured by the FIFO on `fifo_push`. Write data from the FIFO head (`wr_word`) is driven on `ad` during write data phases and consumed on `fifo_pop`.

The controller has five states:
- `ST_IDLE` goes to `ST_HOLD` on `start` (load).
- `ST_HOLD` goes to `ST_IDLE` when the count is zero (done). It goes to `ST_REQ` when the FIFO has room.
- `ST_REQ` goes to `ST_ADDR` on grant.
- `ST_ADDR` goes to `ST_DATA` unconditionally.
- `ST_DATA` stays in `ST_DATA` during wait states and after a completed phase that has a successor. It goes back to `ST_HOLD` after the final phase of the ownership.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset `bus_req`, `frame`, `addr_phase`, `data_phase`, `busy`, `done`, `fifo_push` and `fifo_pop` are low and `be_n` is 4'b1111.
- R2: `bus_req` rises only while work remains and the FIFO has room: for reads `fifo_level < hi_wm`, for writes `fifo_level > lo_wm`. The address phase starts on the cycle after `bus_req` and `bus_gnt` are both sampled high.
- R3: In an address phase `ad` carries the current word address with `ad[1:0] = 2'b00`. Successive data phases, across ownerships too, advance by exactly one 32-bit word from the start address.
- R4: When the burst-enable bit of the current direction (`burst_rd_en` for reads, `burst_wr_en` for writes) is clear, each ownership has exactly one data phase and `frame` is low during it.
- R5: In burst mode `frame` is high in the address phase and in every data phase except the final one of the ownership, and every address phase is followed by a data phase.
- R6: In read data phases (`dir_wr = 0`) `be_n` is 4'b0000. The remaining count drops by the number of requested bytes in that word.
- R7: In write data phases `be_n[i]` is low exactly when byte lane i (byte offset i in the word) lies inside the buffer. A start at offset 1 gives a first phase of 4'b0001. Nine bytes from an aligned address give 4'b0000, 4'b0000, 4'b1110. A middle phase of a burst always enables all four lanes.
- R8: A data phase completes only on a clock edge where `trdy` is high. While `trdy` is low, the phase, its byte enables and the address/count hold, and neither `fifo_push` nor `fifo_pop` is asserted.
- R9: In burst mode a read phase is the last one of its ownership when `fifo_level + 1 >= hi_wm`, and a write phase is the last when `fifo_level - 1 <= lo_wm`. With level L at ownership start, this gives `hi_wm - L` read phases or `L - lo_wm` write phases, unless fewer words remain.
- R10: If `bus_gnt` is low during a data phase, that phase is the last of the ownership. The block later raises `bus_req` again and resumes at the next word.
- R11: Each completed read phase pulses `fifo_push` and each completed write phase pulses `fifo_pop`. When the remaining count is zero, `done` pulses for one cycle and the block returns to idle. A zero-length job raises `done` without any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job (sampled in idle) |
| dir_wr | input | 1 | 1 = write memory from FIFO, 0 = read memory into FIFO |
| start_addr | input | BUS_W | Start byte address |
| start_len | input | LW | Job length in bytes |
| burst_rd_en | input | 1 | Allow bursts for reads |
| burst_wr_en | input | 1 | Allow bursts for writes |
| fifo_level | input | FW | FIFO occupancy in words |
| hi_wm | input | FW | Read stop threshold |
| lo_wm | input | FW | Write stop threshold |
| wr_word | input | BUS_W | FIFO head word for writes |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| frame | output | 1 | Transaction framing, low in the final phase |
| addr_phase | output | 1 | Address phase marker |
| data_phase | output | 1 | Data phase marker (initiator ready) |
| ad | output | BUS_W | Address or write data |
| be_n | output | 4 | Active-low byte enables |
| trdy | input | 1 | Target ready |
| fifo_push | output | 1 | FIFO captures read data |
| fifo_pop | output | 1 | FIFO advances past write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job-complete pulse |

## Verification
The properties assume that `dir_wr`, both burst enables and both watermarks stay constant from `start` until `done`. They also assume that `trdy` is only meaningful while `data_phase` is high. The bench changes configuration only between jobs, with the block idle. It drives `bus_gnt`, `trdy` and the FIFO level from a model that updates the level on the same clock edges where the block pushes or pops. Refills happen only while `bus_req` is low, so no watermark moves beneath an ownership in progress.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_REQ,
        ST_ADDR,
        ST_DATA
    } seq_state_t;
endpackage

// File: rtl/dma_lane_calc.sv
// Bytes served by the current word and the lanes they occupy.
module dma_lane_calc #(
    parameter int LW = 12
) (
    input  logic [1:0]    off,
    input  logic [LW-1:0] rem,
    output logic [2:0]    nbytes,
    output logic [3:0]    mask
);
    logic [2:0] head;
    assign head   = 3'd4 - {1'b0, off};
    assign nbytes = (rem < LW'(head)) ? rem[2:0] : head;

    logic [3:0] lo_edge, hi_edge;
    assign lo_edge = {2'b00, off};
    assign hi_edge = {2'b00, off} + {1'b0, nbytes};

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign mask[i] = (4'(i) >= lo_edge) && (4'(i) < hi_edge);
    end
endmodule

// File: rtl/dma_track.sv
// Address cursor and remaining byte count.
module dma_track #(
    parameter int BUS_W = 32,
    parameter int LW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] ld_addr,
    input  logic [LW-1:0]    ld_len,
    input  logic             step,
    input  logic [2:0]       step_bytes,
    output logic [BUS_W-1:0] cur_addr,
    output logic [LW-1:0]    rem
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem      <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            rem      <= ld_len;
        end else if (step) begin
            cur_addr <= {cur_addr[BUS_W-1:2] + 1'b1, 2'b00};
            rem      <= rem - LW'(step_bytes);
        end
    end
endmodule

// File: rtl/dma_room.sv
// Watermark comparisons now and one word ahead.
module dma_room #(
    parameter int FW = 6
) (
    input  logic          dir_wr,
    input  logic [FW-1:0] level,
    input  logic [FW-1:0] hi_wm,
    input  logic [FW-1:0] lo_wm,
    output logic          room_now,
    output logic          room_next
);
    localparam int XW = FW + 1;
    logic [XW-1:0] lvl_x, hi_x, lo_x;
    assign lvl_x = {1'b0, level};
    assign hi_x  = {1'b0, hi_wm};
    assign lo_x  = {1'b0, lo_wm};

    assign room_now  = dir_wr ? (level > lo_wm) : (level < hi_wm);
    assign room_next = dir_wr ? (lvl_x > lo_x + XW'(1)) : (lvl_x + XW'(1) < hi_x);
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int LW    = 12,
    parameter int FW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_wr,
    input  logic [BUS_W-1:0] start_addr,
    input  logic [LW-1:0]    start_len,
    input  logic             burst_rd_en,
    input  logic             burst_wr_en,
    input  logic [FW-1:0]    fifo_level,
    input  logic [FW-1:0]    hi_wm,
    input  logic [FW-1:0]    lo_wm,
    input  logic [BUS_W-1:0] wr_word,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             frame,
    output logic             addr_phase,
    output logic             data_phase,
    output logic [BUS_W-1:0] ad,
    output logic [3:0]       be_n,
    input  logic             trdy,
    output logic             fifo_push,
    output logic             fifo_pop,
    output logic             busy,
    output logic             done
);
    seq_state_t state_q, state_d;

    logic [BUS_W-1:0] cur_addr;
    logic [LW-1:0]    rem, rem_after;
    logic [2:0]       nbytes;
    logic [3:0]       mask;
    logic             room_now, room_next;
    logic             burst_ok, more, phase_done, load;

    dma_track #(.BUS_W(BUS_W), .LW(LW)) u_track (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_addr(start_addr), .ld_len(start_len),
        .step(phase_done), .step_bytes(nbytes),
        .cur_addr(cur_addr), .rem(rem)
    );

    dma_lane_calc #(.LW(LW)) u_lane (
        .off(cur_addr[1:0]), .rem(rem), .nbytes(nbytes), .mask(mask)
    );

    dma_room #(.FW(FW)) u_room (
        .dir_wr(dir_wr), .level(fifo_level), .hi_wm(hi_wm), .lo_wm(lo_wm),
        .room_now(room_now), .room_next(room_next)
    );

    assign burst_ok   = dir_wr ? burst_wr_en : burst_rd_en;
    assign rem_after  = rem - LW'(nbytes);
    assign more       = burst_ok && (rem_after != '0) && room_next && bus_gnt;
    assign phase_done = (state_q == ST_DATA) && trdy;
    assign load       = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HOLD;
            ST_HOLD: begin
                if (rem == '0)    state_d = ST_IDLE;
                else if (room_now) state_d = ST_REQ;
            end
            ST_REQ:  if (bus_gnt) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: if (trdy && !more) state_d = ST_HOLD;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req    = 1'b0;
        frame      = 1'b0;
        addr_phase = 1'b0;
        data_phase = 1'b0;
        ad         = '0;
        be_n       = 4'b1111;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: done = (rem == '0);
            ST_REQ:  bus_req = 1'b1;
            ST_ADDR: begin
                bus_req    = 1'b1;
                frame      = 1'b1;
                addr_phase = 1'b1;
                ad         = {cur_addr[BUS_W-1:2], 2'b00};
            end
            ST_DATA: begin
                bus_req    = 1'b1;
                frame      = more;
                data_phase = 1'b1;
                ad         = dir_wr ? wr_word : '0;
                be_n       = dir_wr ? ~mask : 4'b0000;
            end
            default: ;
        endcase
    end

    assign fifo_push = phase_done && !dir_wr;
    assign fifo_pop  = phase_done && dir_wr;
    assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_wr,
    input logic       burst_rd_en,
    input logic       burst_wr_en,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       trdy,
    input logic       frame,
    input logic       addr_phase,
    input logic       data_phase,
    input logic [1:0] ad_lo,
    input logic [3:0] be_n
);
    // R2
    addr_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_phase) |-> $past(bus_req && bus_gnt));

    // R3
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (ad_lo == 2'b00));

    // R4
    single_phase_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !(dir_wr ? burst_wr_en : burst_rd_en)) |-> !frame);

    // R5
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> data_phase);

    // R5
    addr_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> frame);

    // R6
    read_lanes_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !dir_wr) |-> (be_n == 4'b0000));

    // R7
    middle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && dir_wr && frame && $past(data_phase && trdy && frame))
            |-> (be_n == 4'b0000));

    // R8
    wait_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !trdy) |=> (data_phase && $stable(be_n)));
endmodule

bind dma_burst_seq dma_burst_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr),
    .burst_rd_en(burst_rd_en), .burst_wr_en(burst_wr_en),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .trdy(trdy), .frame(frame),
    .addr_phase(addr_phase), .data_phase(data_phase),
    .ad_lo(ad[1:0]), .be_n(be_n)
);

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_wr = 1'b0;
    logic [31:0] start_addr = '0;
    logic [11:0] start_len = '0;
    logic        burst_rd_en = 1'b0, burst_wr_en = 1'b0;
    logic [5:0]  fifo_level = '0, hi_wm = 6'd60, lo_wm = 6'd0;
    logic [31:0] wr_word = 32'h5A5A_0000;
    logic        bus_gnt = 1'b0, trdy = 1'b0;
    logic        bus_req, frame, addr_phase, data_phase, fifo_push, fifo_pop, busy, done;
    logic [31:0] ad;
    logic [3:0]  be_n;

    dma_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
        .start_addr(start_addr), .start_len(start_len),
        .burst_rd_en(burst_rd_en), .burst_wr_en(burst_wr_en),
        .fifo_level(fifo_level), .hi_wm(hi_wm), .lo_wm(lo_wm), .wr_word(wr_word),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .frame(frame),
        .addr_phase(addr_phase), .data_phase(data_phase), .ad(ad), .be_n(be_n),
        .trdy(trdy), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    int trdy_mode = 0, tcnt = 0;
    bit preempt_mode = 0, refill_mode = 0, lvl_set = 0, prev_req = 0;
    logic [5:0] refill_val = '0, lvl_val = '0;
    logic [31:0] exp_addr;
    int exp_rem = 0, ph_cnt = 0, exp_ph = 0, cool = 0, n_addr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // FIFO occupancy model: moves on the same edges as the block's push/pop
    always @(posedge clk) begin
        cycles++;
        if (lvl_set)                              fifo_level <= lvl_val;
        else if (refill_mode && busy && !bus_req) fifo_level <= refill_val;
        else fifo_level <= fifo_level + 6'(fifo_push) - 6'(fifo_pop);
    end

    // Target/arbiter drive and monitor
    always @(negedge clk) begin
        bit bok;
        int words, room, nb, off, want;
        logic [3:0] m, exp_be;
        tcnt++;
        if (preempt_mode && data_phase && ph_cnt == 2) begin
            bus_gnt = 1'b0; cool = 4;
        end else if (cool > 0) begin
            bus_gnt = 1'b0; cool--;
        end else begin
            bus_gnt = bus_req;
        end
        trdy = (trdy_mode == 0) ? 1'b1 : ((tcnt % 3) != 0);
        #1;
        bok = dir_wr ? burst_wr_en : burst_rd_en;
        if (bus_req && !prev_req) begin
            room = dir_wr ? (int'(fifo_level) > int'(lo_wm)) : (int'(fifo_level) < int'(hi_wm));
            check(room != 0 && exp_rem > 0, "R2", "request without room or work", fifo_level, 0);
        end
        prev_req = bus_req;
        if (addr_phase) begin
            n_addr++;
            check(ad == {exp_addr[31:2], 2'b00}, "R3", "address phase", ad, {exp_addr[31:2], 2'b00});
            words = (int'(exp_addr[1:0]) + exp_rem + 3) / 4;
            room  = dir_wr ? int'(fifo_level) - int'(lo_wm) : int'(hi_wm) - int'(fifo_level);
            exp_ph = bok ? imin(words, room) : 1;
            ph_cnt = 0;
        end
        if (data_phase) begin
            if (!bok) check(!frame, "R4", "frame in single data phase", frame, 0);
            if (trdy) begin
                off = int'(exp_addr[1:0]);
                nb  = imin(4 - off, exp_rem);
                for (int i = 0; i < 4; i++) m[i] = (i >= off) && (i < off + nb);
                exp_be = dir_wr ? ~m : 4'b0000;
                check(be_n == exp_be, dir_wr ? "R7" : "R6", "byte enables", be_n, exp_be);
                check(fifo_push == !dir_wr && fifo_pop == dir_wr, "R11", "push/pop",
                      {fifo_push, fifo_pop}, {!dir_wr, dir_wr});
                exp_addr = {exp_addr[31:2] + 30'd1, 2'b00};
                exp_rem -= nb;
                ph_cnt++;
                if (!frame) begin
                    want = preempt_mode ? imin(exp_ph, 3) : exp_ph;
                    check(ph_cnt == want, preempt_mode ? "R10" : (bok ? "R9" : "R4"),
                          "phases per ownership", ph_cnt, want);
                end else begin
                    check(bok, "R5", "frame high only in burst", frame, bok);
                end
            end else begin
                check(!fifo_push && !fifo_pop, "R8", "push/pop in wait state",
                      {fifo_push, fifo_pop}, 0);
            end
        end
    end

    task automatic run(input bit wr, input bit ben, input logic [31:0] addr, input int len,
                       input logic [5:0] lvl, input logic [5:0] hi, input logic [5:0] lo);
        int t;
        @(negedge clk);
        dir_wr = wr; burst_rd_en = ben; burst_wr_en = ben;
        hi_wm = hi; lo_wm = lo; start_addr = addr; start_len = 12'(len);
        lvl_val = lvl; lvl_set = 1;
        @(negedge clk);
        lvl_set = 0;
        exp_addr = addr; exp_rem = len; n_addr = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            #2;
            t++;
        end
        check(done == 1'b1, "R11", "done seen", done, 1);
        check(exp_rem == 0, "R11", "bytes remaining at done", exp_rem, 0);
        @(negedge clk);
        #2;
        check(!busy && !done, "R11", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_req && !frame && !addr_phase && !data_phase && !busy && !done
              && !fifo_push && !fifo_pop, "R1", "reset outputs",
              {bus_req, frame, addr_phase, data_phase, busy, done, fifo_push, fifo_pop}, 0);
        check(be_n == 4'b1111, "R1", "reset byte enables", be_n, 4'hF);
        rst_n = 1;

        // Sweep: direction, burst enable, wait-state pattern, start offset, length
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 2; b++)
                for (int tm = 0; tm < 2; tm++)
                    for (int o = 0; o < 4; o++)
                        for (int l = 1; l <= 9; l++) begin
                            trdy_mode = tm;
                            run(d[0], b[0], 32'h0000_1000 + 32'(o), l,
                                d ? 6'd40 : 6'd0, 6'd60, 6'd0);
                        end

        // R7: nine bytes aligned, burst write -> 0000,0000,1110 in one ownership
        trdy_mode = 0;
        run(1'b1, 1'b1, 32'h0000_2000, 9, 6'd40, 6'd60, 6'd0);
        check(n_addr == 1, "R7", "nine-byte burst ownerships", n_addr, 1);

        // R11: zero-length job completes without a request
        run(1'b0, 1'b1, 32'h0000_3000, 0, 6'd0, 6'd60, 6'd0);
        check(n_addr == 0, "R11", "zero length address phases", n_addr, 0);

        // R9: read stops at high watermark (3 words per ownership)
        refill_mode = 1; refill_val = 6'd0;
        run(1'b0, 1'b1, 32'h0000_0100, 40, 6'd0, 6'd3, 6'd0);
        check(n_addr == 4, "R9", "read ownerships", n_addr, 4);

        // R9: write stops at low watermark (4 words per ownership)
        refill_val = 6'd10;
        run(1'b1, 1'b1, 32'h0000_0200, 40, 6'd10, 6'd60, 6'd6);
        check(n_addr == 3, "R9", "write ownerships", n_addr, 3);
        refill_mode = 0;

        // R10: grant withdrawn after two phases, with wait states
        preempt_mode = 1;
        run(1'b1, 1'b1, 32'h0000_0400, 40, 6'd40, 6'd60, 6'd0);
        check(n_addr == 4, "R10", "preempted ownerships", n_addr, 4);
        trdy_mode = 1;
        run(1'b0, 1'b1, 32'h0000_0502, 30, 6'd0, 6'd60, 6'd0);
        check(n_addr == 3, "R10", "preempted read ownerships", n_addr, 3);
        preempt_mode = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule